// File: doc/BRIEF.md
# Indexed Absolute Address Sequencer

This block steps through the bus cycles that turn an absolute base address and an 8-bit index into the effective address of a data access. It is used inside a 6502-family core. The core accepts a request on `start` while `ready` is high. With the request it supplies the 16-bit base taken from the operand bytes, the index register value, the current program counter, the access kind, which register indexes (X or Y), and whether the core runs as the original NMOS part or the CMOS variant.

The sequencer first forms a partial address. It keeps the high byte of the base and replaces the low byte with the low byte of the sum. It may then spend one bus cycle on a throwaway read. On the NMOS personality that read goes to the partial address. On the CMOS personality it can go to PC-1 instead. Whether the read happens at all depends on the personality, the access kind, the index register and whether the addition carried into the high byte. Finally the block presents the corrected effective address with a one-cycle `done` pulse. The core then runs its own data cycle.

Each bus cycle advances only on a clock where `step` is high. `page_cross` reports the carry out of the low-byte addition while a request is in progress.

Top module: `abs_index_seq`

## Requirements
- R1: After a synchronous reset (`rst_n` low at a clock edge), `ready` is 1, `done` is 0, `bus_rd` is 0 and `bus_addr` is 0.
- R2: A request is accepted only while `ready` is 1. A `start` pulse while a request is in progress has no effect on the effective address that the request finally delivers.
- R3: In the cycle after a request is accepted (the index cycle), `bus_addr` equals {high byte of base, low byte of base+index} and `bus_rd` is 0.
- R4: `page_cross` is 1 exactly when the low-byte addition carries. The sum is unsigned and wraps modulo 65536, so base 0xFFFF plus index 0x01 gives 0x0000 with `page_cross` = 1.
- R5: On the NMOS personality (`cmos_mode` = 0), a read (`acc_kind` = 0, and the unused code 3 acts as a read) inserts a throwaway read only when a page is crossed, and that read goes to the partial address.
- R6: On the NMOS personality, a write (`acc_kind` = 1) or read-modify-write (`acc_kind` = 2) always inserts a throwaway read at the partial address.
- R7: On the CMOS personality (`cmos_mode` = 1), a read inserts a throwaway read only when a page is crossed, and that read goes to PC-1.
- R8: On the CMOS personality, an X-indexed write (`idx_y` = 0) always inserts a throwaway read. The read goes to PC-1 if a page was crossed, and to the partial address otherwise.
- R9: On the CMOS personality, a Y-indexed write (`idx_y` = 1) always inserts a throwaway read at PC-1.
- R10: On the CMOS personality, a read-modify-write inserts no throwaway read, whether or not a page is crossed.
- R11: The index cycle and the throwaway-read cycle each last until a clock edge with `step` = 1. While `step` is 0, `bus_addr`, `bus_rd` and `done` hold their values.
- R12: The cycle that follows the last stepped cycle raises `done` for exactly one cycle, with `eff_addr` and `bus_addr` both equal to base+index modulo 65536. `ready` returns to 1 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request valid; accepted when `ready` is 1 |
| base_addr | input | 16 | Absolute base address |
| index_val | input | 8 | Index register value |
| pc_val | input | 16 | Program counter at request time |
| cmos_mode | input | 1 | 1 = CMOS personality, 0 = NMOS |
| idx_y | input | 1 | 1 = Y-indexed, 0 = X-indexed |
| acc_kind | input | 2 | 0 read, 1 write, 2 read-modify-write, 3 treated as read |
| step | input | 1 | Advance enable for the current bus cycle |
| ready | output | 1 | Idle and able to accept a request |
| bus_addr | output | 16 | Address of the current address-forming cycle |
| bus_rd | output | 1 | Throwaway-read strobe |
| page_cross | output | 1 | Carry out of the low-byte addition |
| done | output | 1 | Effective address valid (one-cycle pulse) |
| eff_addr | output | 16 | Corrected effective address |

## Verification
The hardest case to reach is the CMOS X-indexed write, where the dummy address switches between the partial target and PC-1 on nothing but the carry. The bench runs that case twice with the same base and program counter. It changes only the index, so that the carry appears in one run and not in the other. It also drives the wrap from 0xFFFF, holds `step` low inside both stepped cycles, and fires a second `start` mid-sequence with a different base. In each of these runs the bench checks the bus address and the final effective address cycle by cycle.

// File: rtl/aidx_pkg.sv
// Package: shared types for the indexed absolute address sequencer.
// Assumes the core encodes access kinds as listed in acc_kind_t.
package aidx_pkg;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_RMW   = 2'd2,
        ACC_SPARE = 2'd3
    } acc_kind_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_INDEX = 2'd1,
        ST_DUMMY = 2'd2,
        ST_DONE  = 2'd3
    } seq_state_t;

endpackage

// File: rtl/aidx_sum.sv
// Module: aidx_sum
// Forms the full wrapped sum of base and index, plus the partial address
// that keeps the base high field and takes the sum low field.
// Assumes IDX_W <= LOW_W, so a crossing changes the high field by one at most.
module aidx_sum #(
    parameter int ADDR_W = 16,
    parameter int IDX_W  = 8,
    parameter int LOW_W  = 8
) (
    input  logic [ADDR_W-1:0] base_i,
    input  logic [IDX_W-1:0]  idx_i,
    output logic [ADDR_W-1:0] full_o,
    output logic [ADDR_W-1:0] partial_o,
    output logic              crossed_o
);
    localparam int HIGH_W = ADDR_W - LOW_W;

    logic [LOW_W:0] low_sum;

    // Low-field addition with carry, and the wrapped full sum.
    always_comb begin
        low_sum   = {1'b0, base_i[LOW_W-1:0]} + (LOW_W+1)'(idx_i);
        full_o    = base_i + ADDR_W'(idx_i);
        partial_o = {base_i[ADDR_W-1 -: HIGH_W], low_sum[LOW_W-1:0]};
        crossed_o = low_sum[LOW_W];
    end
endmodule

// File: rtl/aidx_policy.sv
// Module: aidx_policy
// Decides whether a throwaway read is inserted and where it is directed,
// from the personality, the access kind, the index register and the carry.
// Pure combinational; inputs come from the sequencer's latched request.
module aidx_policy
    import aidx_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              cmos_i,
    input  logic              idx_y_i,
    input  acc_kind_t         kind_i,
    input  logic              crossed_i,
    input  logic [ADDR_W-1:0] partial_i,
    input  logic [ADDR_W-1:0] pc_i,
    output logic              need_o,
    output logic [ADDR_W-1:0] addr_o
);
    logic [ADDR_W-1:0] pc_back;

    // Address of the byte before the program counter.
    always_comb pc_back = pc_i - ADDR_W'(1);

    // Per-personality selection of dummy need and target.
    always_comb begin
        need_o = 1'b0;
        addr_o = partial_i;
        if (!cmos_i) begin
            unique case (kind_i)
                ACC_WRITE, ACC_RMW: need_o = 1'b1;
                default:            need_o = crossed_i;
            endcase
        end else begin
            unique case (kind_i)
                ACC_WRITE: begin
                    need_o = 1'b1;
                    addr_o = (idx_y_i || crossed_i) ? pc_back : partial_i;
                end
                ACC_RMW: need_o = 1'b0;
                default: begin
                    need_o = crossed_i;
                    addr_o = pc_back;
                end
            endcase
        end
    end
endmodule

// File: rtl/abs_index_seq.sv
// Module: abs_index_seq (top)
// Sequences the address-forming cycles of absolute indexed addressing:
// index cycle, optional throwaway read, then the effective-address cycle.
// Assumes the core holds its request inputs only in the accepting cycle;
// everything needed later is latched here.
module abs_index_seq
    import aidx_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int IDX_W  = 8,
    parameter int LOW_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [IDX_W-1:0]  index_val,
    input  logic [ADDR_W-1:0] pc_val,
    input  logic              cmos_mode,
    input  logic              idx_y,
    input  logic [1:0]        acc_kind,
    input  logic              step,
    output logic              ready,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_rd,
    output logic              page_cross,
    output logic              done,
    output logic [ADDR_W-1:0] eff_addr
);
    seq_state_t        state_q;
    logic [ADDR_W-1:0] base_q;
    logic [IDX_W-1:0]  idx_q;
    logic [ADDR_W-1:0] pc_q;
    logic              cmos_q;
    logic              y_q;
    acc_kind_t         kind_q;

    logic [ADDR_W-1:0] full_sum;
    logic [ADDR_W-1:0] partial_addr;
    logic              crossed;
    logic              need_dummy;
    logic [ADDR_W-1:0] dummy_addr;

    aidx_sum #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .LOW_W(LOW_W)) u_sum (
        .base_i    (base_q),
        .idx_i     (idx_q),
        .full_o    (full_sum),
        .partial_o (partial_addr),
        .crossed_o (crossed)
    );

    aidx_policy #(.ADDR_W(ADDR_W)) u_policy (
        .cmos_i    (cmos_q),
        .idx_y_i   (y_q),
        .kind_i    (kind_q),
        .crossed_i (crossed),
        .partial_i (partial_addr),
        .pc_i      (pc_q),
        .need_o    (need_dummy),
        .addr_o    (dummy_addr)
    );

    // Latch the request when idle and accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            idx_q  <= '0;
            pc_q   <= '0;
            cmos_q <= 1'b0;
            y_q    <= 1'b0;
            kind_q <= ACC_READ;
        end else if (state_q == ST_IDLE && start) begin
            base_q <= base_addr;
            idx_q  <= index_val;
            pc_q   <= pc_val;
            cmos_q <= cmos_mode;
            y_q    <= idx_y;
            kind_q <= acc_kind_t'(acc_kind);
        end
    end

    // Cycle sequencing, gated by step in the two bus cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:  if (start) state_q <= ST_INDEX;
                ST_INDEX: if (step)  state_q <= need_dummy ? ST_DUMMY : ST_DONE;
                ST_DUMMY: if (step)  state_q <= ST_DONE;
                default:             state_q <= ST_IDLE;
            endcase
        end
    end

    // Output decode per cycle.
    always_comb begin
        ready      = (state_q == ST_IDLE);
        bus_rd     = (state_q == ST_DUMMY);
        done       = (state_q == ST_DONE);
        page_cross = (state_q != ST_IDLE) && crossed;
        eff_addr   = full_sum;
        unique case (state_q)
            ST_INDEX: bus_addr = partial_addr;
            ST_DUMMY: bus_addr = dummy_addr;
            ST_DONE:  bus_addr = full_sum;
            default:  bus_addr = '0;
        endcase
    end

    // R12: done lasts one cycle and hands back to idle.
    a_r12_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && ready));

    // R2: a start while busy leaves the delivered address untouched.
    a_r2_busy_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready && start) |=> $stable(eff_addr));

    // R11: without step the bus cycle holds.
    a_r11_step_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && (bus_rd || (!ready && !done))) |=> ($stable(bus_addr) && $stable(bus_rd)));

    // R10: CMOS read-modify-write never reaches a throwaway read.
    a_r10_cmos_rmw_no_dummy: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |-> !(cmos_q && kind_q == ACC_RMW));

    // R6: NMOS throwaway reads stay in the base page.
    a_r6_nmos_dummy_page: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !cmos_q) |-> (bus_addr[ADDR_W-1 -: ADDR_W-LOW_W] == base_q[ADDR_W-1 -: ADDR_W-LOW_W]));

    // R3: no read strobe alongside done.
    a_r3_strobe_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |-> !done);
endmodule

// File: tb/abs_index_seq_bench.sv
`timescale 1ns/1ps
module abs_index_seq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] base_addr = '0;
    logic [7:0]  index_val = '0;
    logic [15:0] pc_val = '0;
    logic        cmos_mode = 1'b0;
    logic        idx_y = 1'b0;
    logic [1:0]  acc_kind = '0;
    logic        step = 1'b0;
    logic        ready, bus_rd, page_cross, done;
    logic [15:0] bus_addr, eff_addr;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    abs_index_seq u_abs_index_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
        .index_val(index_val), .pc_val(pc_val), .cmos_mode(cmos_mode),
        .idx_y(idx_y), .acc_kind(acc_kind), .step(step), .ready(ready),
        .bus_addr(bus_addr), .bus_rd(bus_rd), .page_cross(page_cross),
        .done(done), .eff_addr(eff_addr)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Expected dummy decision, written from the requirements.
    function automatic logic [16:0] expect_dummy(input logic cm, input logic y, input logic [1:0] k,
                                                 input logic cr, input logic [15:0] part, input logic [15:0] pc);
        logic need;
        logic [15:0] a;
        a = part;
        if (!cm) need = (k == 2'd1 || k == 2'd2) ? 1'b1 : cr;      // R5, R6
        else if (k == 2'd1) begin need = 1'b1; a = (y || cr) ? pc - 16'd1 : part; end  // R8, R9
        else if (k == 2'd2) need = 1'b0;                            // R10
        else begin need = cr; a = pc - 16'd1; end                   // R7
        return {need, a};
    endfunction

    // One full request; optional hold cycles and a busy start poke.
    task automatic run_req(input string tag, input logic [15:0] b, input logic [7:0] ix,
                           input logic [15:0] pc, input logic cm, input logic y,
                           input logic [1:0] k, input int hold, input bit poke);
        logic [15:0] full, part;
        logic cr;
        logic [16:0] d;
        full = b + {8'd0, ix};
        part = {b[15:8], full[7:0]};
        cr   = ({1'b0, b[7:0]} + {1'b0, ix}) > 9'h0FF;
        d    = expect_dummy(cm, y, k, cr, part, pc);
        @(negedge clk);
        chk({tag, " R2 ready"}, 16'(ready), 16'd1);
        start = 1'b1; base_addr = b; index_val = ix; pc_val = pc;
        cmos_mode = cm; idx_y = y; acc_kind = k; step = 1'b0;
        @(negedge clk);
        start = 1'b0;
        chk({tag, " R3 partial"}, bus_addr, part);
        chk({tag, " R3 no strobe"}, 16'(bus_rd), 16'd0);
        chk({tag, " R4 cross"}, 16'(page_cross), 16'(cr));
        for (int i = 0; i < hold; i++) begin
            @(negedge clk);
            chk({tag, " R11 hold index"}, bus_addr, part);
            chk({tag, " R11 no done"}, 16'(done), 16'd0);
        end
        if (poke) begin
            start = 1'b1; base_addr = b ^ 16'h5A5A; index_val = ix ^ 8'h33;
        end
        step = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (d[16]) begin
            chk({tag, " R5-R9 strobe"}, 16'(bus_rd), 16'd1);
            chk({tag, " R5-R9 dummy addr"}, bus_addr, d[15:0]);
            if (hold > 0) begin
                step = 1'b0;
                for (int i = 0; i < hold; i++) begin
                    @(negedge clk);
                    chk({tag, " R11 hold dummy"}, 16'(bus_rd), 16'd1);
                end
                step = 1'b1;
            end
            @(negedge clk);
        end
        chk({tag, " R10 R12 done"}, 16'(done), 16'd1);
        chk({tag, " R12 no strobe"}, 16'(bus_rd), 16'd0);
        chk({tag, " R12 eff"}, eff_addr, full);
        chk({tag, " R12 bus"}, bus_addr, full);
        step = 1'b0;
        @(negedge clk);
        chk({tag, " R12 pulse"}, 16'(done), 16'd0);
        chk({tag, " R12 ready"}, 16'(ready), 16'd1);
    endtask

    task automatic test_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 ready", 16'(ready), 16'd1);
        chk("R1 done", 16'(done), 16'd0);
        chk("R1 rd", 16'(bus_rd), 16'd0);
        chk("R1 addr", bus_addr, 16'd0);
        rst_n = 1'b1;
    endtask

    initial begin
        test_reset();
        run_req("nmos rd nocross R5", 16'h1220, 8'h10, 16'h0400, 1'b0, 1'b0, 2'd0, 0, 0);
        run_req("nmos rd cross R5",   16'h12F0, 8'h20, 16'h0400, 1'b0, 1'b0, 2'd0, 0, 0);
        run_req("nmos spare R5",      16'h12F0, 8'h20, 16'h0400, 1'b0, 1'b1, 2'd3, 0, 0);
        run_req("nmos wr R6",         16'h3010, 8'h05, 16'h0800, 1'b0, 1'b0, 2'd1, 0, 0);
        run_req("nmos rmw cross R6",  16'h30FF, 8'h05, 16'h0800, 1'b0, 1'b0, 2'd2, 0, 0);
        run_req("cmos rd nocross R7", 16'h4000, 8'h7F, 16'h9000, 1'b1, 1'b1, 2'd0, 0, 0);
        run_req("cmos rd cross R7",   16'h40C0, 8'h7F, 16'h9000, 1'b1, 1'b0, 2'd0, 0, 0);
        run_req("cmos xwr nocross R8",16'h50A0, 8'h10, 16'hA123, 1'b1, 1'b0, 2'd1, 0, 0);
        run_req("cmos xwr cross R8",  16'h50A0, 8'h70, 16'hA123, 1'b1, 1'b0, 2'd1, 0, 0);
        run_req("cmos ywr R9",        16'h5001, 8'h02, 16'h0000, 1'b1, 1'b1, 2'd1, 0, 0);
        run_req("cmos rmw cross R10", 16'h60F0, 8'h40, 16'h2000, 1'b1, 1'b0, 2'd2, 0, 0);
        run_req("cmos rmw flat R10",  16'h6010, 8'h40, 16'h2000, 1'b1, 1'b0, 2'd2, 0, 0);
        run_req("wrap R4",            16'hFFFF, 8'h01, 16'h1000, 1'b0, 1'b0, 2'd1, 0, 0);
        run_req("hold R11",           16'h70E0, 8'h30, 16'h3000, 1'b0, 1'b0, 2'd1, 3, 0);
        run_req("busy start R2",      16'h7011, 8'h22, 16'h3000, 1'b0, 1'b0, 2'd0, 1, 1);
        test_reset();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        #800000;
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule